// File: doc/BRIEF.md
# I2C Slave Address Status Tracker

This block sits beside the receive shift register of an I2C target interface and follows the first byte after each START condition. It compares that byte with a programmed own-address value and keeps three receive status flags. The first flag holds the last received bit or acknowledge value. The second reports a general call. The third reports that the block has been addressed. Bit sampling, shifting and bus driving are handled elsewhere. This block only receives the finished byte with a strobe, the sampled acknowledge bit, the START and STOP detect pulses, and a strobe for each write to the data shift register.

Each flag has its own set and clear events. The general-call flag drops at any bus condition (START or STOP). The address-match flag stays through bus conditions and drops only when the data shift register is written. Both drop when the interface is disabled. A 7-bit or 10-bit compare mode selects which bits of the first byte must agree with the own-address value.

Top module: `i2c_addr_flags`

## Requirements
- R1: After reset, `last_bit_o`, `gcall_o` and `addr_hit_o` are all 0.
- R2: With `en`=1, an `ack_strobe` pulse loads `ack_bit` into `last_bit_o` at the next edge: 0 means an acknowledge was returned, 1 means none was returned.
- R3: With `en`=1 and no `ack_strobe`, a `byte_done` pulse loads `rx_byte[0]`, the final bit on the wire since bytes arrive MSB first, into `last_bit_o`.
- R4: With `en`=1, a `dsr_wr` pulse without `ack_strobe` or `byte_done` in the same cycle clears `last_bit_o` at the next edge.
- R5: In slave mode with `en`=1, a first byte after START equal to 0x00 sets both `gcall_o` and `addr_hit_o`, in either address format.
- R6: With `fmt_10bit`=0, `addr_hit_o` sets when `rx_byte[7:1]` equals `own_addr[7:1]`. Bit 0 (the read/write bit) is ignored.
- R7: With `fmt_10bit`=1, `addr_hit_o` sets only when all 8 bits of `rx_byte` equal `own_addr`.
- R8: `gcall_o` clears at the edge after a `start_det` or `stop_det` pulse. `dsr_wr` does not clear it.
- R9: `addr_hit_o` clears at the edge after a `dsr_wr` pulse. `start_det` and `stop_det` do not clear it.
- R10: While `en`=0, `gcall_o` and `addr_hit_o` are 0 from the next edge on, and `last_bit_o` holds its value.
- R11: Only the first `byte_done` after a START is compared. Later bytes of the same transfer, and any byte while `slave_mode`=0, leave both match flags unchanged.
- R12: If a set event and a clear event for the same flag occur in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Interface enable |
| slave_mode | input | 1 | 1 when the interface acts as target |
| fmt_10bit | input | 1 | 1 selects 10-bit first-byte compare, 0 selects 7-bit |
| own_addr | input | 8 | Programmed own-address value (address bits plus bit 0) |
| start_det | input | 1 | One-cycle START detect pulse |
| stop_det | input | 1 | One-cycle STOP detect pulse |
| byte_done | input | 1 | One-cycle strobe when `rx_byte` is complete |
| rx_byte | input | 8 | Received byte, bit 0 is the last bit on the wire |
| ack_strobe | input | 1 | One-cycle strobe on the acknowledge clock |
| ack_bit | input | 1 | Sampled SDA on the acknowledge clock |
| dsr_wr | input | 1 | Strobe for a write to the data shift register |
| last_bit_o | output | 1 | Last received bit / acknowledge flag |
| gcall_o | output | 1 | General call detected |
| addr_hit_o | output | 1 | Own address (or general call) matched |

## Verification
The compare is driven with first bytes that differ from the own address only in bit 0. The 7-bit mode must accept these bytes and the 10-bit mode must reject them, which separates the two formats. An all-zero byte is tried in both formats and against an all-zero own address. This separates a general call from a plain address match, because only the former raises `gcall_o`. The same matching byte is also sent as a second byte and while the interface is not in slave mode, which shows that only the first byte after START is compared. Clear events are paired with set events in the same cycle and applied to each flag in turn. This shows which events clear which flag and that the set wins.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // All-zero first byte: general call
  function automatic logic is_gcall(input byte_t b);
    return (b == '0);
  endfunction

  // Address compare: 10-bit mode uses all bits, 7-bit mode ignores bit 0
  function automatic logic own_match(input logic fmt10, input byte_t own, input byte_t b);
    if (fmt10) return (b == own);
    return (b[BYTE_W-1:1] == own[BYTE_W-1:1]);
  endfunction
endpackage

// File: rtl/i2c_first_byte_tracker.sv
module i2c_first_byte_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start_det,
  input  logic stop_det,
  input  logic byte_done,
  output logic first_pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     first_pending <= 1'b0;
    else if (!en)                   first_pending <= 1'b0;
    else if (start_det)             first_pending <= 1'b1;
    else if (stop_det || byte_done) first_pending <= 1'b0;
  end
endmodule

// File: rtl/i2c_addr_compare.sv
module i2c_addr_compare
  import i2c_addr_pkg::*;
(
  input  logic  eval,
  input  logic  fmt_10bit,
  input  byte_t own_addr,
  input  byte_t rx_byte,
  output logic  gcall_set,
  output logic  match_set
);
  logic gc_hit;
  assign gc_hit    = is_gcall(rx_byte);
  assign gcall_set = eval && gc_hit;
  assign match_set = eval && (gc_hit || own_match(fmt_10bit, own_addr, rx_byte));
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic gcall_set,
  input  logic match_set,
  input  logic bus_cond,
  input  logic dsr_wr,
  input  logic ack_strobe,
  input  logic ack_bit,
  input  logic byte_done,
  input  logic rx_lsb,
  output logic last_bit_o,
  output logic gcall_o,
  output logic addr_hit_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcall_o    <= 1'b0;
      addr_hit_o <= 1'b0;
      last_bit_o <= 1'b0;
    end else if (!en) begin
      gcall_o    <= 1'b0;
      addr_hit_o <= 1'b0;
    end else begin
      if (gcall_set)     gcall_o <= 1'b1;
      else if (bus_cond) gcall_o <= 1'b0;

      if (match_set)   addr_hit_o <= 1'b1;
      else if (dsr_wr) addr_hit_o <= 1'b0;

      if (ack_strobe)     last_bit_o <= ack_bit;
      else if (byte_done) last_bit_o <= rx_lsb;
      else if (dsr_wr)    last_bit_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_addr_flags.sv
module i2c_addr_flags
  import i2c_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              slave_mode,
  input  logic              fmt_10bit,
  input  logic [BYTE_W-1:0] own_addr,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              ack_strobe,
  input  logic              ack_bit,
  input  logic              dsr_wr,
  output logic              last_bit_o,
  output logic              gcall_o,
  output logic              addr_hit_o
);
  logic first_pending;
  logic eval;
  logic gcall_set;
  logic match_set;
  logic bus_cond;

  assign eval     = en && slave_mode && byte_done && first_pending;
  assign bus_cond = start_det || stop_det;

  i2c_first_byte_tracker trk_i (
    .clk(clk), .rst_n(rst_n), .en(en), .start_det(start_det),
    .stop_det(stop_det), .byte_done(byte_done), .first_pending(first_pending)
  );

  i2c_addr_compare cmp_i (
    .eval(eval), .fmt_10bit(fmt_10bit), .own_addr(own_addr), .rx_byte(rx_byte),
    .gcall_set(gcall_set), .match_set(match_set)
  );

  i2c_status_flags flg_i (
    .clk(clk), .rst_n(rst_n), .en(en), .gcall_set(gcall_set), .match_set(match_set),
    .bus_cond(bus_cond), .dsr_wr(dsr_wr), .ack_strobe(ack_strobe), .ack_bit(ack_bit),
    .byte_done(byte_done), .rx_lsb(rx_byte[0]), .last_bit_o(last_bit_o),
    .gcall_o(gcall_o), .addr_hit_o(addr_hit_o)
  );
endmodule

// File: rtl/i2c_addr_flags_chk.sv
module i2c_addr_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       slave_mode,
  input logic       start_det,
  input logic       stop_det,
  input logic       byte_done,
  input logic [7:0] rx_byte,
  input logic       ack_strobe,
  input logic       ack_bit,
  input logic       dsr_wr,
  input logic       first_pending,
  input logic       gcall_set,
  input logic       match_set,
  input logic       last_bit_o,
  input logic       gcall_o,
  input logic       addr_hit_o
);
  AST_ACK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ack_strobe) |=> (last_bit_o == $past(ack_bit))); // R2
  AST_WR_CLEARS_LRB: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dsr_wr && !ack_strobe && !byte_done) |=> !last_bit_o); // R4
  AST_GCALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gcall_o) |-> ($past(byte_done) && ($past(rx_byte) == 8'h00))); // R5
  AST_GCALL_BUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (start_det || stop_det) && !gcall_set) |=> !gcall_o); // R8
  AST_HIT_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dsr_wr && !match_set) |=> !addr_hit_o); // R9
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gcall_o && !addr_hit_o)); // R10
  AST_FIRST_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_hit_o) |-> $past(byte_done && first_pending && slave_mode)); // R11
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    gcall_set |=> (gcall_o && addr_hit_o)); // R12
endmodule

bind i2c_addr_flags i2c_addr_flags_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .slave_mode(slave_mode), .start_det(start_det),
  .stop_det(stop_det), .byte_done(byte_done), .rx_byte(rx_byte), .ack_strobe(ack_strobe),
  .ack_bit(ack_bit), .dsr_wr(dsr_wr), .first_pending(first_pending), .gcall_set(gcall_set),
  .match_set(match_set), .last_bit_o(last_bit_o), .gcall_o(gcall_o), .addr_hit_o(addr_hit_o)
);

// File: tb/i2c_addr_flags_tb_top.sv
module i2c_addr_flags_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, slave_mode = 1'b0, fmt_10bit = 1'b0;
  logic [7:0] own_addr = 8'h00, rx_byte = 8'h00;
  logic start_det = 1'b0, stop_det = 1'b0, byte_done = 1'b0;
  logic ack_strobe = 1'b0, ack_bit = 1'b0, dsr_wr = 1'b0;
  logic last_bit_o, gcall_o, addr_hit_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_addr_flags dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .slave_mode(slave_mode), .fmt_10bit(fmt_10bit),
    .own_addr(own_addr), .start_det(start_det), .stop_det(stop_det), .byte_done(byte_done),
    .rx_byte(rx_byte), .ack_strobe(ack_strobe), .ack_bit(ack_bit), .dsr_wr(dsr_wr),
    .last_bit_o(last_bit_o), .gcall_o(gcall_o), .addr_hit_o(addr_hit_o)
  );

  // {fmt10, slave, own[7:0], byte[7:0], exp_hit, exp_gcall}
  localparam logic [19:0] VEC [8] = '{
    {1'b0, 1'b1, 8'hA4, 8'hA5, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'hA4, 8'hA6, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'hF2, 8'hF2, 1'b1, 1'b0},
    {1'b1, 1'b1, 8'hF2, 8'hF3, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h30, 8'h00, 1'b1, 1'b1},
    {1'b0, 1'b0, 8'hA4, 8'hA4, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h5A, 8'h00, 1'b1, 1'b1},
    {1'b0, 1'b1, 8'h00, 8'h01, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Pulse helpers: drive at negedge, release at the following negedge
  task automatic pulse_start();
    start_det = 1'b1; @(negedge clk); start_det = 1'b0;
  endtask
  task automatic pulse_stop();
    stop_det = 1'b1; @(negedge clk); stop_det = 1'b0;
  endtask
  task automatic pulse_wr();
    dsr_wr = 1'b1; @(negedge clk); dsr_wr = 1'b0;
  endtask
  task automatic pulse_byte(input logic [7:0] b);
    rx_byte = b; byte_done = 1'b1; @(negedge clk); byte_done = 1'b0;
  endtask
  task automatic pulse_ack(input logic a);
    ack_bit = a; ack_strobe = 1'b1; @(negedge clk); ack_strobe = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "last_bit", last_bit_o, 1'b0);
    chk("R1", "gcall", gcall_o, 1'b0);
    chk("R1", "addr_hit", addr_hit_o, 1'b0);
    rst_n = 1'b1; en = 1'b1;
    @(negedge clk);

    // Table walk: R3, R5, R6, R7, R11
    for (int i = 0; i < 8; i++) begin
      logic [19:0] v;
      string tag;
      v = VEC[i];
      fmt_10bit = v[19]; slave_mode = v[18]; own_addr = v[17:10];
      tag = !v[18] ? "R11" : v[0] ? "R5" : v[19] ? "R7" : "R6";
      pulse_wr(); pulse_stop(); pulse_start();
      pulse_byte(v[9:2]);
      chk(tag, "addr_hit", addr_hit_o, v[1]);
      chk(tag, "gcall", gcall_o, v[0]);
      chk("R3", "last_bit", last_bit_o, v[2]);
    end

    // R2: ack and no-ack
    slave_mode = 1'b1; fmt_10bit = 1'b0; own_addr = 8'hA4;
    pulse_ack(1'b1); chk("R2", "nack", last_bit_o, 1'b1);
    pulse_ack(1'b0); chk("R2", "ack", last_bit_o, 1'b0);
    pulse_ack(1'b1);
    // R4: write clears last bit
    pulse_wr(); chk("R4", "last_bit", last_bit_o, 1'b0);

    // R8 / R9: general call, then individual clear events
    pulse_stop(); pulse_start(); pulse_byte(8'h00);
    pulse_wr();
    chk("R8", "gcall kept on write", gcall_o, 1'b1);
    chk("R9", "hit cleared on write", addr_hit_o, 1'b0);
    pulse_stop();
    chk("R8", "gcall cleared on stop", gcall_o, 1'b0);
    pulse_start(); pulse_byte(8'h00); pulse_start();
    chk("R8", "gcall cleared on start", gcall_o, 1'b0);
    chk("R9", "hit kept on start", addr_hit_o, 1'b1);
    pulse_stop();
    chk("R9", "hit kept on stop", addr_hit_o, 1'b1);

    // R11: second byte of a transfer is not compared
    pulse_wr(); pulse_start(); pulse_byte(8'h10); pulse_byte(8'hA4);
    chk("R11", "second byte", addr_hit_o, 1'b0);

    // R12: set wins against write (hit) and against stop (gcall)
    pulse_start();
    rx_byte = 8'hA4; byte_done = 1'b1; dsr_wr = 1'b1; @(negedge clk);
    byte_done = 1'b0; dsr_wr = 1'b0;
    chk("R12", "hit with write", addr_hit_o, 1'b1);
    pulse_start();
    rx_byte = 8'h00; byte_done = 1'b1; stop_det = 1'b1; @(negedge clk);
    byte_done = 1'b0; stop_det = 1'b0;
    chk("R12", "gcall with stop", gcall_o, 1'b1);

    // R10: disable clears match flags, last bit holds, no set while disabled
    pulse_ack(1'b1);
    en = 1'b0; @(negedge clk);
    chk("R10", "gcall off", gcall_o, 1'b0);
    chk("R10", "hit off", addr_hit_o, 1'b0);
    pulse_ack(1'b0);
    chk("R10", "last_bit held", last_bit_o, 1'b1);
    pulse_start(); pulse_byte(8'h00);
    chk("R10", "no set disabled", addr_hit_o, 1'b0);
    en = 1'b1; @(negedge clk);

    done = 1'b1;
    summary();
  end
endmodule